// File: doc/BRIEF.md
# Alternating Channel-Group Conversion Sequencer

This block decides which of several channel-group slots owns an analog-to-digital converter at any time. Each slot holds a 5-bit channel number, an interrupt enable, the last result it received and a completion flag. A single mode input selects how conversions begin. In software mode, writing slot 0 launches a conversion on the channel just written. In hardware mode, a set of per-slot trigger inputs launches conversions, and the slots take turns in a fixed rotation.

The converter is modelled inside the block as a busy/done handshake with a fixed latency of `CONV_CYCLES` clock cycles. When a conversion finishes, the `adc_sample` value is stored in the slot that owned the conversion. Writing the owning slot part-way through a conversion aborts it. Software reads any slot's result and flag through a combinational read port, and a single interrupt line collects the enabled completion flags.

Top module: `chgrp_sequencer`

## Requirements
- R1: After reset `active`, `irq` and every slot's completion flag are 0, every slot's result reads 0, and the hardware rotation points at slot 0.
- R2: In software mode (`hw_mode`=0), a write to slot 0 makes `active` high from the next cycle for exactly `CONV_CYCLES` cycles, with `conv_chan` equal to the written channel and `act_grp` equal to 0.
- R3: When a conversion finishes, the owning slot's result takes the value of `adc_sample` in the last busy cycle, its completion flag goes to 1 and `active` falls.
- R4: A write never starts a conversion in these cases: the write is to a slot other than 0, or the block is in hardware mode.
- R5: In hardware mode, with the converter idle, a high `hw_trig[k]` starts a conversion on slot k only when k is the slot next in the rotation 0,1,...,N-1,0. Triggers on other bits are ignored, and each start moves the rotation on by one.
- R6: A trigger that arrives while a conversion is in progress is ignored and does not move the rotation.
- R7: Writing a slot other than the owning one during a conversion changes neither the conversion's length nor its channel nor its destination.
- R8: Writing the owning slot during a conversion aborts it. No result is stored and no flag is set. In software mode a write to slot 0 then restarts at once on the new channel, so the full `CONV_CYCLES` count begins again.
- R9: Any write to a slot clears that slot's completion flag.
- R10: In software mode with `cont_en`=1, a finished slot-0 conversion restarts slot 0 in the same cycle, so `active` stays high. Each pass stores a new result.
- R11: `irq` is high exactly when some slot has both its completion flag and its interrupt enable set.
- R12: At most one slot receives a completion per cycle, and the owning slot does not change while a conversion is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_mode | input | 1 | 1 = hardware-trigger mode, 0 = software-trigger mode |
| cont_en | input | 1 | Continuous restart of slot 0 in software mode |
| wr_en | input | 1 | Slot write strobe |
| wr_grp | input | GW | Slot written (must be below NUM_GROUPS) |
| wr_chan | input | 5 | Channel number to store |
| wr_ie | input | 1 | Interrupt enable to store |
| hw_trig | input | NUM_GROUPS | Per-slot hardware trigger, level sampled each cycle |
| adc_sample | input | RES_W | Converter output, taken in the last busy cycle |
| rd_grp | input | GW | Slot selected for reading |
| rd_result | output | RES_W | Stored result of the selected slot |
| rd_done | output | 1 | Completion flag of the selected slot |
| active | output | 1 | Conversion in progress |
| act_grp | output | GW | Slot that owns the current or last conversion |
| conv_chan | output | 5 | Channel of the current or last conversion |
| irq | output | 1 | Enabled completion pending |

## Verification
The hardest conditions to reach are a slot write that lands in the same window as a running conversion: on the owning slot, which aborts it, and on the other slot, which must not disturb it. The bench places each write a fixed number of cycles after the start, so it arrives mid-conversion. It then checks that the earlier result survives an abort, and that a slot-0 restart takes the full latency measured from the second write. Rotation order is tested by issuing the out-of-turn trigger first and a trigger during a busy period, then showing that the next accepted trigger is still the expected slot.

// File: rtl/chgrp_pkg.sv
// Shared definitions for the channel-group sequencer.
// Assumes the channel field width is fixed at 5 bits (channels 0..31).
package chgrp_pkg;
    localparam int CH_W = 5;
    typedef logic [CH_W-1:0] chan_t;
endpackage

// File: rtl/chgrp_timer.sv
// Fixed-latency converter model: busy for LAT cycles after a start.
// A start takes priority over a kill; fin flags the last busy cycle.
// Assumes LAT >= 2.
module chgrp_timer #(
    parameter int LAT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic kill,
    output logic busy,
    output logic fin
);
    localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;

    logic [CW-1:0] cnt;

    assign fin = busy && (cnt == '0);

    // Count down the remaining busy cycles of the running conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(LAT - 1);
        end else if (kill || fin) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R2: a conversion with cycles left and no kill stays busy
    a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cnt != '0) && !kill) |=> busy);
endmodule

// File: rtl/chgrp_bank.sv
// One channel-group slot: channel, interrupt enable, result, completion flag.
// A write clears the flag; a completion stores the sample and sets it.
// Assumes the controller never asserts wr and done for one slot together.
module chgrp_bank #(
    parameter int RES_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  chgrp_pkg::chan_t   wr_chan,
    input  logic               wr_ie,
    input  logic               done,
    input  logic [RES_W-1:0]   sample,
    output chgrp_pkg::chan_t   chan,
    output logic               ie,
    output logic [RES_W-1:0]   result,
    output logic               coco
);
    // Hold the slot settings and the last completed result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan   <= '0;
            ie     <= 1'b0;
            result <= '0;
            coco   <= 1'b0;
        end else if (wr) begin
            chan <= wr_chan;
            ie   <= wr_ie;
            coco <= 1'b0;
        end else if (done) begin
            result <= sample;
            coco   <= 1'b1;
        end
    end

    // R9: a write leaves the flag clear
    a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !coco);
    // R3: the flag only rises on a completion
    a_r3_flag_from_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coco) |-> $past(done));
endmodule

// File: rtl/chgrp_ctrl.sv
// Ownership control: decides starts, aborts and completions, keeps the
// owning slot, the conversion channel and the hardware rotation pointer.
// Assumes wr_grp < NUM_GROUPS.
module chgrp_ctrl #(
    parameter int NUM_GROUPS = 2,
    parameter int GW         = 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  hw_mode,
    input  logic                                  cont_en,
    input  logic                                  wr_en,
    input  logic [GW-1:0]                         wr_grp,
    input  chgrp_pkg::chan_t                      wr_chan,
    input  logic [NUM_GROUPS-1:0]                 hw_trig,
    input  logic [NUM_GROUPS-1:0][chgrp_pkg::CH_W-1:0] grp_chan,
    input  logic                                  busy,
    input  logic                                  fin,
    output logic                                  start,
    output logic                                  kill,
    output logic [NUM_GROUPS-1:0]                 done_vec,
    output logic [GW-1:0]                         act_grp,
    output chgrp_pkg::chan_t                      conv_chan
);
    logic [GW-1:0]    ptr;
    logic             wr_hits_act;
    logic             sw_start;
    logic             hw_start;
    logic             cont_start;
    logic             complete;
    logic [GW-1:0]    start_grp;
    chgrp_pkg::chan_t start_chan;

    // Decide this cycle's start, abort and completion events.
    always_comb begin
        wr_hits_act = wr_en && busy && (wr_grp == act_grp);
        sw_start    = !hw_mode && wr_en && (wr_grp == '0) &&
                      (!busy || (act_grp == '0));
        hw_start    = hw_mode && !busy && hw_trig[ptr];
        complete    = fin && !wr_hits_act;
        cont_start  = complete && cont_en && !hw_mode && (act_grp == '0);
        start       = sw_start || hw_start || cont_start;
        kill        = wr_hits_act;
        start_grp   = hw_start ? ptr : '0;
        start_chan  = sw_start ? wr_chan : grp_chan[start_grp];
    end

    // Route a completion to the owning slot only.
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            done_vec[g] = complete && (act_grp == GW'(g));
        end
    end

    // Record ownership on each start and advance the rotation on hardware starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_grp   <= '0;
            conv_chan <= '0;
            ptr       <= '0;
        end else begin
            if (start) begin
                act_grp   <= start_grp;
                conv_chan <= start_chan;
            end
            if (hw_start) begin
                if (ptr == GW'(NUM_GROUPS - 1)) ptr <= '0;
                else                            ptr <= ptr + 1'b1;
            end
        end
    end

    // R12: one completion per cycle at most
    a_r12_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_vec));
    // R12: ownership is fixed while a conversion runs
    a_r12_owner_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(act_grp));
    // R4: software can only launch slot 0
    a_r4_sw_slot0_only: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !hw_mode) |=> (act_grp == '0));
    // R8: an abort yields no completion
    a_r8_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        kill |-> (done_vec == '0));
    // R6: the rotation does not move while busy
    a_r6_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr));
endmodule

// File: rtl/chgrp_sequencer.sv
// Top: channel-group slots sharing one fixed-latency converter, started by
// software writes to slot 0 or by per-slot hardware triggers in rotation.
// Assumes wr_grp and rd_grp are below NUM_GROUPS.
module chgrp_sequencer #(
    parameter int NUM_GROUPS  = 2,
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 8,
    localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hw_mode,
    input  logic                  cont_en,
    input  logic                  wr_en,
    input  logic [GW-1:0]         wr_grp,
    input  logic [4:0]            wr_chan,
    input  logic                  wr_ie,
    input  logic [NUM_GROUPS-1:0] hw_trig,
    input  logic [RES_W-1:0]      adc_sample,
    input  logic [GW-1:0]         rd_grp,
    output logic [RES_W-1:0]      rd_result,
    output logic                  rd_done,
    output logic                  active,
    output logic [GW-1:0]         act_grp,
    output logic [4:0]            conv_chan,
    output logic                  irq
);
    logic                                       start, kill, fin;
    logic [NUM_GROUPS-1:0]                      done_vec;
    logic [NUM_GROUPS-1:0][chgrp_pkg::CH_W-1:0] grp_chan;
    logic [NUM_GROUPS-1:0]                      grp_ie;
    logic [NUM_GROUPS-1:0]                      grp_coco;
    logic [NUM_GROUPS-1:0][RES_W-1:0]           grp_res;

    chgrp_timer #(.LAT(CONV_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .kill(kill),
        .busy(active), .fin(fin)
    );

    chgrp_ctrl #(.NUM_GROUPS(NUM_GROUPS), .GW(GW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .cont_en(cont_en),
        .wr_en(wr_en), .wr_grp(wr_grp), .wr_chan(wr_chan), .hw_trig(hw_trig),
        .grp_chan(grp_chan), .busy(active), .fin(fin), .start(start),
        .kill(kill), .done_vec(done_vec), .act_grp(act_grp),
        .conv_chan(conv_chan)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
        chgrp_bank #(.RES_W(RES_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .wr(wr_en && (wr_grp == GW'(g))),
            .wr_chan(wr_chan), .wr_ie(wr_ie),
            .done(done_vec[g]), .sample(adc_sample),
            .chan(grp_chan[g]), .ie(grp_ie[g]),
            .result(grp_res[g]), .coco(grp_coco[g])
        );
    end

    // Read port and interrupt collection.
    always_comb begin
        rd_result = grp_res[rd_grp];
        rd_done   = grp_coco[rd_grp];
        irq       = |(grp_coco & grp_ie);
    end

    // R11: interrupt tracks enabled flags
    a_r11_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(grp_coco & grp_ie)));
    // R1: idle and quiet in the cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!active && !irq));
endmodule

// File: tb/chgrp_sequencer_test.sv
module chgrp_sequencer_test;
    localparam int N   = 2;
    localparam int RW  = 12;
    localparam int LAT = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hw_mode = 1'b0, cont_en = 1'b0;
    logic          wr_en = 1'b0, wr_ie = 1'b0;
    logic [0:0]    wr_grp = '0, rd_grp = '0;
    logic [4:0]    wr_chan = '0;
    logic [N-1:0]  hw_trig = '0;
    logic [RW-1:0] adc_sample = '0;
    logic [RW-1:0] rd_result;
    logic          rd_done, active, irq;
    logic [0:0]    act_grp;
    logic [4:0]    conv_chan;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    chgrp_sequencer #(.NUM_GROUPS(N), .RES_W(RW), .CONV_CYCLES(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .cont_en(cont_en),
        .wr_en(wr_en), .wr_grp(wr_grp), .wr_chan(wr_chan), .wr_ie(wr_ie),
        .hw_trig(hw_trig), .adc_sample(adc_sample), .rd_grp(rd_grp),
        .rd_result(rd_result), .rd_done(rd_done), .active(active),
        .act_grp(act_grp), .conv_chan(conv_chan), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic rd(input int g);
        rd_grp = 1'(g);
        #1;
    endtask

    // Drive a slot write on one edge; returns at the following negedge.
    task automatic wr(input int g, input int ch, input bit ie);
        wr_en = 1'b1; wr_grp = 1'(g); wr_chan = 5'(ch); wr_ie = ie;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic trig(input int g);
        hw_trig = '0; hw_trig[g] = 1'b1;
        @(posedge clk); @(negedge clk);
        hw_trig = '0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 active", active, 0);
        chk("R1 irq", irq, 0);
        for (int g = 0; g < N; g++) begin
            rd(g);
            chk("R1 flag", rd_done, 0);
            chk("R1 result", rd_result, 0);
        end
    endtask

    task automatic t_sw_basic;
        adc_sample = 12'h123;
        wr(0, 5, 1);
        chk("R2 active start", active, 1);
        chk("R2 channel", conv_chan, 5);
        chk("R2 owner", act_grp, 0);
        wait_n(LAT - 1);
        chk("R2 still active at last cycle", active, 1);
        wait_n(1);
        chk("R3 active falls", active, 0);
        rd(0);
        chk("R3 result", rd_result, 12'h123);
        chk("R3 flag", rd_done, 1);
        chk("R11 irq set", irq, 1);
    endtask

    task automatic t_clear;
        wr(0, 3, 0);
        rd(0);
        chk("R9 flag cleared", rd_done, 0);
        chk("R11 irq clear", irq, 0);
        wait_n(LAT);
        chk("R11 irq stays low with enable off", irq, 0);
        chk("R3 flag after second run", rd_done, 1);
    endtask

    task automatic t_nostart;
        wr(1, 9, 0);
        chk("R4 slot1 write no start", active, 0);
        hw_mode = 1'b1;
        wr(0, 1, 0);
        chk("R4 hw mode write no start", active, 0);
        hw_mode = 1'b0;
    endtask

    task automatic t_other_write;
        adc_sample = 12'h0AA;
        wr(0, 7, 0);
        wait_n(2);
        wr(1, 12, 0);
        chk("R7 still active", active, 1);
        chk("R7 channel kept", conv_chan, 7);
        wait_n(LAT - 4);
        chk("R7 length kept", active, 1);
        wait_n(1);
        chk("R7 ends on time", active, 0);
        rd(0);
        chk("R7 result in slot0", rd_result, 12'h0AA);
        rd(1);
        chk("R7 slot1 no flag", rd_done, 0);
    endtask

    task automatic t_sw_restart;
        adc_sample = 12'h3C3;
        wr(0, 6, 0);
        wait_n(3);
        wr(0, 11, 0);
        chk("R8 restart active", active, 1);
        chk("R8 restart channel", conv_chan, 11);
        wait_n(LAT - 1);
        chk("R8 full latency from rewrite", active, 1);
        rd(0);
        chk("R8 no early flag", rd_done, 0);
        wait_n(1);
        chk("R8 restart completes", active, 0);
        chk("R8 restart result", rd_result, 12'h3C3);
    endtask

    task automatic t_hw;
        hw_mode = 1'b1;
        wr(0, 1, 0);
        wr(1, 2, 0);
        trig(1);
        chk("R5 out-of-turn trigger ignored", active, 0);
        adc_sample = 12'h511;
        trig(0);
        chk("R5 slot0 starts", active, 1);
        chk("R5 slot0 channel", conv_chan, 1);
        chk("R5 owner 0", act_grp, 0);
        wait_n(2);
        trig(1);
        wait_n(LAT - 4);
        chk("R6 busy trigger no extension", active, 1);
        wait_n(1);
        chk("R6 idle after run", active, 0);
        rd(0);
        chk("R5 slot0 result", rd_result, 12'h511);
        rd(1);
        chk("R6 slot1 untouched", rd_done, 0);
        adc_sample = 12'h622;
        trig(1);
        chk("R5 slot1 next in turn", active, 1);
        chk("R5 slot1 channel", conv_chan, 2);
        chk("R5 owner 1", act_grp, 1);
        wait_n(LAT);
        chk("R3 slot1 result", rd_result, 12'h622);
        chk("R3 slot1 flag", rd_done, 1);
        rd(0);
        chk("R9 slot0 flag kept", rd_done, 1);
        trig(1);
        chk("R5 wrap: slot1 ignored", active, 0);
        trig(0);
        chk("R5 wrap: slot0 starts", active, 1);
        wait_n(LAT);
        // abort: rotation now at slot1
        adc_sample = 12'h7F7;
        trig(1);
        wait_n(2);
        wr(1, 4, 0);
        chk("R8 abort stops", active, 0);
        wait_n(LAT + 2);
        rd(1);
        chk("R8 no result stored", rd_result, 12'h622);
        chk("R8 no flag", rd_done, 0);
        hw_mode = 1'b0;
    endtask

    task automatic t_cont;
        cont_en = 1'b1;
        adc_sample = 12'h055;
        wr(0, 2, 0);
        wait_n(LAT);
        rd(0);
        chk("R10 first result", rd_result, 12'h055);
        chk("R10 flag", rd_done, 1);
        chk("R10 restarted", active, 1);
        adc_sample = 12'h066;
        wait_n(LAT);
        chk("R10 second result", rd_result, 12'h066);
        chk("R10 still running", active, 1);
        cont_en = 1'b0;
        wait_n(LAT);
        chk("R10 stops when off", active, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sw_basic();
        t_clear();
        t_nostart();
        t_other_write();
        t_sw_restart();
        t_hw();
        t_cont();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule